// File: doc/BRIEF.md
# Pulse-Width Symbol Decoder

This block turns a demodulated, already digital data line into a serial bit stream. The line carries self-clocked symbols. Every symbol begins with a rising edge, and the value of its bit lies in how long the line stays high compared with the symbol's full length. A half-high symbol means 0. A symbol that is high for about three tenths of its length means 1. No baud rate is configured. The decoder counts cycles of a fast sampling clock between consecutive rising edges, so it follows whatever symbol rate arrives. Each symbol is judged against its own measured length.

Downstream command logic receives three things: a one-cycle strobe with the decoded bit, a regenerated symbol clock, and an idle flag. The symbol clock goes high after every accepted symbol start and stays high for half of the last measured period. The decoder treats a long silence as loss of signal. After reset or after such a silence, it needs one whole symbol to settle before it emits any bits.

Top module: `pwm_symbol_decoder`

## Requirements
- R1: The line input passes through two sampling-clock flip-flops before edge detection. For a symbol that completes a bit, `bit_valid` is low at the second clock edge after the line is first sampled high and is high at the third.
- R2: The period P is the number of sampling cycles between two consecutive rising edges. The high time H is the number of those cycles in which the line is high. The decoded bit is 1 when H*THR_DEN < P*THR_NUM, which is below 40 % with the defaults 2 and 5. Otherwise the bit is 0. A 50 % symbol therefore gives 0 and a 30 % symbol gives 1.
- R3: `bit_valid` is high for exactly one cycle per decoded symbol and never in two consecutive cycles. Every completed tracked symbol after the first yields exactly one strobe.
- R4: After reset or after idle, the first rising edge opens a symbol. The rising edge that closes that first symbol produces no strobe. Bits are produced from the second complete symbol onward.
- R5: If no rising edge arrives within TIMEOUT sampling cycles of the previous one, the open symbol is dropped without a bit and the decoder returns to idle. A period of exactly TIMEOUT is still accepted, because a rising edge wins over the timeout in the same cycle.
- R6: `idle` is high from reset until the first rising edge and again after a timeout. It is low while symbols are being tracked.
- R7: `sym_clk` goes high in the cycle after each rising edge that closes a symbol. It stays high for floor(P/2) cycles, where P is the period just closed. It is low while idle and during the first open symbol.
- R8: While `rst_n` is low at a clock edge, the counters are cleared and the outputs become `bit_valid`=0, `bit_value`=0, `sym_clk`=0, `idle`=1.
- R9: The period may change from one symbol to the next, anywhere from 4 to TIMEOUT cycles, with no configuration. Each bit is decided against its own period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the symbol rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Demodulated pulse-width data line, asynchronous |
| bit_valid | output | 1 | One-cycle strobe marking a decoded bit |
| bit_value | output | 1 | Decoded bit, meaningful while `bit_valid` is high |
| sym_clk | output | 1 | Regenerated symbol clock, high for half the last period |
| idle | output | 1 | High while no symbol stream is being tracked |

## Verification
Two events can fall in the same cycle: the rising edge that closes a symbol, and the timeout that would drop it. The bench provokes this with symbols of exactly TIMEOUT cycles and of TIMEOUT+1 cycles, using a small TIMEOUT. The first kind must still produce bits. The second must leave the decoder idle and start relearning. A full sweep of every high time for every period from 4 to 40 also places the 40 % boundary exactly on an integer, so it judges the strict comparison there.

// File: rtl/pwsd_pkg.sv
// Shared types and default constants for the pulse-width symbol decoder.
// Assumes nothing beyond a single sampling clock domain.
package pwsd_pkg;

    // Tracking state of the symbol framer.
    typedef enum logic [1:0] {
        TRK_SEEK  = 2'd0,   // no stream: waiting for a first rising edge
        TRK_LEARN = 2'd1,   // first symbol open, its period not yet known
        TRK_RUN   = 2'd2    // periods known, every closing edge yields a bit
    } trk_state_t;

    localparam int DEF_TIMEOUT = 4095;  // sampling cycles without an edge before idle
    localparam int DEF_THR_NUM = 2;     // threshold = THR_NUM / THR_DEN of the period
    localparam int DEF_THR_DEN = 5;
    localparam int DEF_STAGES  = 2;     // synchroniser depth

endpackage

// File: rtl/pwsd_edge_sync.sv
// Brings the asynchronous data line into the clock domain and flags rising edges.
// Assumes STAGES >= 2. The edge flag is high for exactly one cycle per low-to-high
// transition of the synchronised level.
module pwsd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic lvl,
    output logic rise
);

    // chain_q[STAGES-1] is the synchronised level; chain_q[STAGES] is its previous value
    logic [STAGES:0] chain_q;

    // Shift the raw line through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], line_in};
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);  // R1

endmodule

// File: rtl/pwsd_interval_meter.sv
// Measures the current symbol: elapsed cycles since the last rising edge and the
// number of those cycles spent high. Both counters restart at each rising edge and
// saturate at the timeout limit, so a silent or stuck line cannot wrap them.
module pwsd_interval_meter #(
    parameter int TIMEOUT = 4095,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             rise,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] period_now,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] HIGH_TOP = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_q;

    // Count cycles since the last rising edge, saturating one short of the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Count high cycles of the open symbol; the rising-edge cycle itself is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (rise) begin
            hi_q <= CNT_W'(1);
        end else if (lvl && hi_q != HIGH_TOP) begin
            hi_q <= hi_q + 1'b1;
        end
    end

    assign elapsed    = cnt_q;
    assign high_cnt   = hi_q;
    assign period_now = cnt_q + 1'b1;   // valid while rise is high
    assign at_limit   = (cnt_q == LAST_CNT);

    AST_HIGH_LE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, hi_q} <= {1'b0, cnt_q} + 1'b1));  // R2

endmodule

// File: rtl/pwsd_framer.sv
// Frames symbols and decides bits. It tracks seek / learn / run, compares the
// high time of each closing symbol with a fixed fraction of that symbol's own
// period, raises the bit strobe and regenerates a half-period symbol clock.
// Assumes that the meter's period_now and high_cnt are valid in the rise cycle.
module pwsd_framer
    import pwsd_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int THR_NUM = 2,
    parameter int THR_DEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             at_limit,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] period_now,
    output logic             bit_valid,
    output logic             bit_value,
    output logic             sym_clk,
    output logic             idle
);

    localparam int PROD_W = CNT_W + 8;  // THR_NUM and THR_DEN below 256

    trk_state_t       state_q;
    logic             valid_q;
    logic             value_q;
    logic             symclk_q;
    logic [CNT_W-1:0] half_q;
    logic [PROD_W-1:0] high_scaled;
    logic [PROD_W-1:0] period_scaled;
    logic             is_one;
    logic             tracking;

    assign high_scaled   = PROD_W'(high_cnt) * PROD_W'(THR_DEN);
    assign period_scaled = PROD_W'(period_now) * PROD_W'(THR_NUM);
    assign is_one        = (high_scaled < period_scaled);
    assign tracking      = (state_q != TRK_SEEK);

    // Advance the tracking state; a closing edge wins over the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_SEEK;
        end else begin
            case (state_q)
                TRK_SEEK:  if (rise) state_q <= TRK_LEARN;
                TRK_LEARN,
                TRK_RUN: begin
                    if (rise)          state_q <= TRK_RUN;
                    else if (at_limit) state_q <= TRK_SEEK;
                end
                default:   state_q <= TRK_SEEK;
            endcase
        end
    end

    // Emit a one-cycle strobe and the decided bit for each symbol closed in run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            value_q <= 1'b0;
        end else begin
            valid_q <= rise && (state_q == TRK_RUN);
            if (rise && (state_q == TRK_RUN)) begin
                value_q <= is_one;
            end
        end
    end

    // Regenerate a symbol clock high for half of the period just closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            symclk_q <= 1'b0;
            half_q   <= '0;
        end else if (rise && tracking) begin
            symclk_q <= 1'b1;
            half_q   <= period_now >> 1;
        end else if (tracking && at_limit) begin
            symclk_q <= 1'b0;
        end else if (symclk_q && (elapsed == half_q - 1'b1)) begin
            symclk_q <= 1'b0;
        end
    end

    assign bit_valid = valid_q;
    assign bit_value = value_q;
    assign sym_clk   = symclk_q;
    assign idle      = (state_q == TRK_SEEK);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);  // R3

    AST_NO_BIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_SEEK) |-> !valid_q);  // R5

    AST_FIRST_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state_q == TRK_LEARN) |=> !valid_q);  // R4

    AST_SYMCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_SEEK) |-> !symclk_q);  // R7

    AST_IDLE_BY_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TRK_SEEK) |-> $past(at_limit));  // R6

endmodule

// File: rtl/pwm_symbol_decoder.sv
// Top of the pulse-width symbol decoder: synchroniser, interval meter and framer.
// Assumes the sampling clock is much faster than the symbol rate and that every
// symbol has at least one low and one high sampling cycle.
module pwm_symbol_decoder
    import pwsd_pkg::*;
#(
    parameter int TIMEOUT = DEF_TIMEOUT,
    parameter int THR_NUM = DEF_THR_NUM,
    parameter int THR_DEN = DEF_THR_DEN,
    parameter int STAGES  = DEF_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_value,
    output logic sym_clk,
    output logic idle
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic             lvl;
    logic             rise;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] period_now;
    logic             at_limit;

    pwsd_edge_sync #(
        .STAGES (STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .lvl     (lvl),
        .rise    (rise)
    );

    pwsd_interval_meter #(
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .rise       (rise),
        .elapsed    (elapsed),
        .high_cnt   (high_cnt),
        .period_now (period_now),
        .at_limit   (at_limit)
    );

    pwsd_framer #(
        .CNT_W   (CNT_W),
        .THR_NUM (THR_NUM),
        .THR_DEN (THR_DEN)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .at_limit   (at_limit),
        .elapsed    (elapsed),
        .high_cnt   (high_cnt),
        .period_now (period_now),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .sym_clk    (sym_clk),
        .idle       (idle)
    );

endmodule

// File: tb/pwm_symbol_decoder_test.sv
// Sweeps the decoder with a small timeout. Expected bits come from H*5 < P*2.
module pwm_symbol_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic bit_valid, bit_value, sym_clk, idle;

    int total = 0;
    int bad = 0;
    int exp_q [256];
    int q_head = 0;
    int q_tail = 0;
    int idx = 0;
    bit prev_pushed = 1'b0;
    int run_len = 0;
    int last_run = 0;
    int nstrobe = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_symbol_decoder #(.TIMEOUT(TMO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bit_valid (bit_valid),
        .bit_value (bit_value),
        .sym_clk   (sym_clk),
        .idle      (idle)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every strobe with the queued expectation; record symbol clock run lengths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                nstrobe++;
                if (q_head == q_tail) begin
                    chk(1'b0, "R3 unexpected strobe", 1, 0);
                end else begin
                    chk(bit_value == exp_q[q_head % 256][0], "R2 R9 bit value",
                        int'(bit_value), exp_q[q_head % 256]);
                    q_head++;
                end
            end
            if (sym_clk) begin
                run_len++;
            end else if (run_len > 0) begin
                last_run = run_len;
                run_len = 0;
            end
        end
    end

    // Drive one symbol of p cycles, high for h; queue its bit when it will be decoded.
    task automatic send_sym(input int p, input int h);
        bit closes;
        bit push;
        closes = prev_pushed;
        push = (idx >= 1) && (p <= TMO);
        idx++;
        if (push) begin
            exp_q[q_tail % 256] = (h * 5 < p * 2) ? 1 : 0;
            q_tail++;
        end
        for (int i = 0; i < p; i++) begin
            line_in = (i < h);
            @(negedge clk);
            if (closes && i == 1) chk(bit_valid == 1'b0, "R1 strobe too early", int'(bit_valid), 0);
            if (closes && i == 2) chk(bit_valid == 1'b1, "R1 strobe latency", int'(bit_valid), 1);
            if (idx >= 2 && i == 2) chk(idle == 1'b0, "R6 idle while tracking", int'(idle), 0);
        end
        prev_pushed = push;
        if (p > TMO) idx = 0;
    endtask

    // Close the open symbol with one edge, then let the line time out.
    task automatic end_burst();
        send_sym(TMO + 8, 2);
        chk(idle == 1'b1, "R5 idle after gap", int'(idle), 1);
        chk(sym_clk == 1'b0, "R7 symbol clock low when idle", int'(sym_clk), 0);
        chk(q_head == q_tail, "R3 all bits delivered", q_tail - q_head, 0);
    endtask

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        chk(bit_valid == 1'b0, "R8 reset strobe", int'(bit_valid), 0);
        chk(bit_value == 1'b0, "R8 reset bit", int'(bit_value), 0);
        chk(sym_clk == 1'b0, "R8 reset symbol clock", int'(sym_clk), 0);
        chk(idle == 1'b1, "R8 reset idle", int'(idle), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(idle == 1'b1, "R6 idle before first edge", int'(idle), 1);

        // R4: first symbol after reset yields no strobe
        s0 = nstrobe;
        send_sym(10, 5);
        send_sym(10, 3);
        chk(nstrobe == s0, "R4 learning symbol silent", nstrobe - s0, 0);
        end_burst();
        chk(last_run == 5, "R7 half period", last_run, 5);

        // R2: every high time for every period 4..40
        for (int p = 4; p <= 40; p++) begin
            for (int h = 1; h < p; h++) send_sym(p, h);
            end_burst();
            chk(last_run == p / 2, "R7 half period sweep", last_run, p / 2);
        end

        // R5: period exactly TIMEOUT is accepted
        send_sym(TMO, 20);
        send_sym(TMO, 30);
        send_sym(TMO, 25);
        send_sym(TMO, 26);
        end_burst();
        chk(last_run == TMO / 2, "R7 half of timeout period", last_run, TMO / 2);

        // R9: periods changing every symbol
        send_sym(8, 2);
        send_sym(40, 20);
        send_sym(17, 5);
        send_sym(5, 1);
        send_sym(33, 13);
        send_sym(12, 5);
        end_burst();

        // R5: one cycle longer than TIMEOUT drops the symbol and relearns
        send_sym(12, 4);
        send_sym(12, 6);
        send_sym(TMO + 1, 10);
        repeat (3) @(negedge clk);
        chk(idle == 1'b1, "R5 timeout reached", int'(idle), 1);
        s0 = nstrobe;
        send_sym(12, 4);
        send_sym(12, 4);
        chk(nstrobe == s0, "R4 relearn after timeout", nstrobe - s0, 0);
        end_burst();

        // R8: reset in the middle of a stream
        send_sym(10, 3);
        send_sym(10, 3);
        send_sym(10, 3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(idle == 1'b1, "R8 mid-run reset idle", int'(idle), 1);
        chk(sym_clk == 1'b0, "R8 mid-run reset symbol clock", int'(sym_clk), 0);
        chk(bit_valid == 1'b0, "R8 mid-run reset strobe", int'(bit_valid), 0);
        rst_n = 1'b1;
        q_tail = q_head;
        idx = 0;
        prev_pushed = 1'b0;
        @(negedge clk);
        send_sym(14, 3);
        send_sym(14, 7);
        send_sym(14, 4);
        end_burst();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        total++;
        bad++;
        $display("FAIL watchdog R3 run did not finish actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule